// File: doc/BRIEF.md
# In-Order Commit Queue with Result Forwarding

This block is a circular queue that tracks instructions between dispatch and retirement in an out-of-order core. At dispatch, each instruction claims the entry at the tail pointer and receives that entry's index as its tag. The entry records the destination register. Execution units later report completion through a single write port, giving the tag, the result value and a fault flag. Completions may arrive in any order. The entry keeps the result as uncommitted, speculative state until the instruction becomes the oldest one in the queue.

Each cycle the block looks at the oldest entry. If that entry has completed without a fault, its result is written into an internal architectural register file and the entry is released. If it completed with a fault, the block signals an exception, drops every entry, and returns both pointers to index zero. A combinational lookup port serves later instructions. It returns the youngest in-flight value for a named register, along with a readiness flag and the producer tag. When no entry in flight targets that register, it returns the committed register value instead.

Top module: `cq_top`

## Requirements
- R1: After reset the queue is empty. `full` is 0, `alloc_tag` is 0, `ret_valid` and `exc_out` are 0, and every register reads as 0 through the lookup port, with `rd_hit`=0 and `rd_ready`=1.
- R2: An allocation request is granted (`alloc_ok`=1) when the queue is not full and no fault is retiring in that cycle. Granted tags follow one another as consecutive indices that wrap from DEPTH-1 back to 0.
- R3: When DEPTH entries are in flight, `full`=1 and `alloc_ok`=0. A refused request takes no entry, so the next granted tag is the index that the oldest entry frees.
- R4: Entries retire strictly in allocation order, at most one per cycle. A retiring entry shows `ret_valid`=1 with its destination and result in the cycle before the clock edge that commits it. This holds whatever the order in which the entries completed.
- R5: An entry that has completed waits while any older entry has not completed, and produces no retirement.
- R6: A retired result is written into the architectural register file. When no entry in flight targets the register, a lookup of it returns the committed value with `rd_ready`=1 and `rd_hit`=0.
- R7: A lookup that matches entries in flight returns the youngest matching entry. It gives `rd_hit`=1 and that entry's tag. `rd_ready` is 0 until the entry completes, and from then on `rd_data` carries its result.
- R8: A faulted entry at the head raises `exc_out`=1 with `exc_tag` set to its index, and allocation is refused in that cycle. After that edge the queue is empty with both pointers at 0, so the next tag is 0. The discarded entries never reach the register file.
- R9: A fault reported for an entry that is not the oldest has no effect until that entry reaches the head. Older entries still retire normally before it.
- R10: A completion that names an entry not in flight is ignored. An instruction that is later allocated to that index starts as not completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Dispatch asks for an entry |
| alloc_dst | input | AREG_W | Destination register of the dispatched instruction |
| alloc_ok | output | 1 | Request granted this cycle |
| alloc_tag | output | TAG_W | Index given to the instruction (tail pointer) |
| full | output | 1 | All DEPTH entries in flight |
| cmp_valid | input | 1 | Completion report valid |
| cmp_tag | input | TAG_W | Entry that completed |
| cmp_data | input | DATA_W | Result value |
| cmp_exc | input | 1 | The instruction faulted |
| ret_valid | output | 1 | Head entry retires at the coming edge |
| ret_dst | output | AREG_W | Destination of the head entry |
| ret_data | output | DATA_W | Result of the head entry |
| exc_out | output | 1 | Head entry faulted; the queue is flushed at the coming edge |
| exc_tag | output | TAG_W | Index of the faulting entry |
| rd_reg | input | AREG_W | Register to look up |
| rd_hit | output | 1 | An entry in flight targets rd_reg |
| rd_ready | output | 1 | rd_data holds a usable value |
| rd_tag | output | TAG_W | Tag of the youngest matching entry |
| rd_data | output | DATA_W | Forwarded or committed value |

## Verification
The hardest situation to reach is a flush that happens while the queue is full and wrapped. In that state a fault waits behind an older, unfinished entry, and a younger entry has already completed. The bench first drains part of the queue so that the head sits at a high index. It then fills all DEPTH entries, so the tags wrap through zero, and attempts one more allocation that must be refused. Next it reports the fault and the younger completion before the oldest completion. Finally it checks that the exception appears only after the older retirement, and that the completed younger value never shows up in the register file.

// File: rtl/cq_pkg.sv
package cq_pkg;

  typedef enum logic [1:0] {
    HEAD_WAIT   = 2'd0,
    HEAD_RETIRE = 2'd1,
    HEAD_FAULT  = 2'd2
  } head_act_e;

endpackage

// File: rtl/cq_ptrs.sv
module cq_ptrs #(
  parameter int DEPTH = 8,
  parameter int TAG_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  output logic [TAG_W-1:0] head,
  output logic [TAG_W-1:0] tail,
  output logic             full
);

  localparam logic [TAG_W-1:0] LAST_IDX = TAG_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);

  logic [TAG_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (flush) begin
      head_d = '0;
      tail_d = '0;
      cnt_d  = '0;
    end else begin
      if (pop) begin
        head_d = (head_q == LAST_IDX) ? '0 : head_q + 1'b1;
      end
      if (push) begin
        tail_d = (tail_q == LAST_IDX) ? '0 : tail_q + 1'b1;
      end
      if (push && !pop) begin
        cnt_d = cnt_q + 1'b1;
      end else if (pop && !push) begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  assign head = head_q;
  assign tail = tail_q;
  assign full = (cnt_q == CNT_MAX);

endmodule

// File: rtl/cq_lookup.sv
module cq_lookup #(
  parameter int DEPTH  = 8,
  parameter int TAG_W  = $clog2(DEPTH),
  parameter int AREG_W = 5,
  parameter int DATA_W = 32
) (
  input  logic [DEPTH-1:0]             vld,
  input  logic [DEPTH-1:0]             done,
  input  logic [DEPTH-1:0][AREG_W-1:0] dst,
  input  logic [DEPTH-1:0][DATA_W-1:0] res,
  input  logic [TAG_W-1:0]             head,
  input  logic [AREG_W-1:0]            rd_reg,
  output logic                         hit,
  output logic                         ready,
  output logic [TAG_W-1:0]             tag,
  output logic [DATA_W-1:0]            data
);

  localparam logic [TAG_W:0] DEPTH_X = (TAG_W + 1)'(DEPTH);

  // Walk from oldest to youngest; a later match overrides an earlier one.
  always_comb begin
    hit   = 1'b0;
    ready = 1'b0;
    tag   = '0;
    data  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      logic [TAG_W:0]   sum;
      logic [TAG_W-1:0] idx;
      sum = {1'b0, head} + (TAG_W + 1)'(i);
      if (sum >= DEPTH_X) begin
        sum = sum - DEPTH_X;
      end
      idx = sum[TAG_W-1:0];
      if (vld[idx] && (dst[idx] == rd_reg)) begin
        hit   = 1'b1;
        ready = done[idx];
        tag   = idx;
        data  = res[idx];
      end
    end
  end

endmodule

// File: rtl/cq_archrf.sv
module cq_archrf #(
  parameter int AREG_W = 5,
  parameter int DATA_W = 32,
  parameter int NREGS  = 2 ** AREG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AREG_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AREG_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [NREGS-1:0][DATA_W-1:0] regs_q;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic en;
    assign en = we && (waddr == AREG_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (en) begin
        regs_q[g] <= wdata;
      end
    end
  end

  assign rdata = regs_q[raddr];

endmodule

// File: rtl/cq_top.sv
module cq_top
  import cq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int AREG_W = 5,
  parameter int DATA_W = 32,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_req,
  input  logic [AREG_W-1:0] alloc_dst,
  output logic              alloc_ok,
  output logic [TAG_W-1:0]  alloc_tag,
  output logic              full,
  input  logic              cmp_valid,
  input  logic [TAG_W-1:0]  cmp_tag,
  input  logic [DATA_W-1:0] cmp_data,
  input  logic              cmp_exc,
  output logic              ret_valid,
  output logic [AREG_W-1:0] ret_dst,
  output logic [DATA_W-1:0] ret_data,
  output logic              exc_out,
  output logic [TAG_W-1:0]  exc_tag,
  input  logic [AREG_W-1:0] rd_reg,
  output logic              rd_hit,
  output logic              rd_ready,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data
);

  logic [TAG_W-1:0] head, tail;
  logic             push, pop, flush;

  logic [DEPTH-1:0] vld_q, vld_d, done_q, done_d, exc_q, exc_d;
  logic [DEPTH-1:0][AREG_W-1:0] dst_q;
  logic [DEPTH-1:0][DATA_W-1:0] res_q;

  logic      cmp_hit;
  head_act_e head_act;

  logic              fwd_hit, fwd_ready;
  logic [TAG_W-1:0]  fwd_tag;
  logic [DATA_W-1:0] fwd_data, rf_rdata;

  // Head decision
  always_comb begin
    if (!(vld_q[head] && done_q[head])) begin
      head_act = HEAD_WAIT;
    end else if (exc_q[head]) begin
      head_act = HEAD_FAULT;
    end else begin
      head_act = HEAD_RETIRE;
    end
  end

  assign pop      = (head_act == HEAD_RETIRE);
  assign flush    = (head_act == HEAD_FAULT);
  assign push     = alloc_req && !full && !flush;
  assign cmp_hit  = cmp_valid && vld_q[cmp_tag];

  cq_ptrs #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_ptrs (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (pop),
    .flush (flush),
    .head  (head),
    .tail  (tail),
    .full  (full)
  );

  // Entry status next state
  always_comb begin
    vld_d  = vld_q;
    done_d = done_q;
    exc_d  = exc_q;
    if (flush) begin
      vld_d  = '0;
      done_d = '0;
      exc_d  = '0;
    end else begin
      if (pop) begin
        vld_d[head]  = 1'b0;
        done_d[head] = 1'b0;
      end
      if (cmp_hit) begin
        done_d[cmp_tag] = 1'b1;
        exc_d[cmp_tag]  = cmp_exc;
      end
      if (push) begin
        vld_d[tail]  = 1'b1;
        done_d[tail] = 1'b0;
        exc_d[tail]  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      done_q <= '0;
      exc_q  <= '0;
    end else begin
      vld_q  <= vld_d;
      done_q <= done_d;
      exc_q  <= exc_d;
    end
  end

  // Payload storage: no reset, explicit per-entry enables
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic dst_we, res_we;
    assign dst_we = push && (tail == TAG_W'(g));
    assign res_we = cmp_hit && (cmp_tag == TAG_W'(g));
    always_ff @(posedge clk) begin
      if (dst_we) begin
        dst_q[g] <= alloc_dst;
      end
      if (res_we) begin
        res_q[g] <= cmp_data;
      end
    end
  end

  cq_archrf #(.AREG_W(AREG_W), .DATA_W(DATA_W)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (pop),
    .waddr (dst_q[head]),
    .wdata (res_q[head]),
    .raddr (rd_reg),
    .rdata (rf_rdata)
  );

  cq_lookup #(
    .DEPTH(DEPTH), .TAG_W(TAG_W), .AREG_W(AREG_W), .DATA_W(DATA_W)
  ) u_lookup (
    .vld    (vld_q),
    .done   (done_q),
    .dst    (dst_q),
    .res    (res_q),
    .head   (head),
    .rd_reg (rd_reg),
    .hit    (fwd_hit),
    .ready  (fwd_ready),
    .tag    (fwd_tag),
    .data   (fwd_data)
  );

  assign alloc_ok  = push;
  assign alloc_tag = tail;
  assign ret_valid = pop;
  assign ret_dst   = dst_q[head];
  assign ret_data  = res_q[head];
  assign exc_out   = flush;
  assign exc_tag   = head;
  assign rd_hit    = fwd_hit;
  assign rd_ready  = fwd_hit ? fwd_ready : 1'b1;
  assign rd_tag    = fwd_tag;
  assign rd_data   = fwd_hit ? fwd_data : rf_rdata;

endmodule

// File: rtl/cq_checker.sv
module cq_checker #(
  parameter int DEPTH = 8,
  parameter int TAG_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_req,
  input logic             alloc_ok,
  input logic [TAG_W-1:0] alloc_tag,
  input logic             full,
  input logic             ret_valid,
  input logic             exc_out,
  input logic             rd_hit,
  input logic             rd_ready
);

  localparam logic [TAG_W-1:0] LAST_IDX = TAG_W'(DEPTH - 1);

  // R3: a full queue grants nothing
  a_r3_no_grant_full: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !alloc_ok);

  // R2: a grant moves the tag by one, wrapping at DEPTH
  a_r2_tag_step: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ok |=> alloc_tag == (($past(alloc_tag) == LAST_IDX) ? '0 : $past(alloc_tag) + 1'b1));

  // R4: one head event at most per cycle
  a_r4_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ret_valid, exc_out}));

  // R8: a fault flush leaves an empty queue with pointers at zero
  a_r8_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    exc_out |=> (alloc_tag == '0) && !full && !ret_valid && !exc_out);

  // R8: no grant while a fault retires
  a_r8_no_grant_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_out && alloc_req) |-> !alloc_ok);

  // R6: a committed value is always ready
  a_r6_miss_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> rd_ready);

endmodule

bind cq_top cq_checker #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_cq_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .alloc_req (alloc_req),
  .alloc_ok  (alloc_ok),
  .alloc_tag (alloc_tag),
  .full      (full),
  .ret_valid (ret_valid),
  .exc_out   (exc_out),
  .rd_hit    (rd_hit),
  .rd_ready  (rd_ready)
);

// File: tb/cq_top_bench.sv
`timescale 1ns/1ps
module cq_top_bench;

  localparam int DEPTH  = 8;
  localparam int AREG_W = 5;
  localparam int DATA_W = 32;
  localparam int TAG_W  = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              alloc_req;
  logic [AREG_W-1:0] alloc_dst;
  logic              alloc_ok;
  logic [TAG_W-1:0]  alloc_tag;
  logic              full;
  logic              cmp_valid;
  logic [TAG_W-1:0]  cmp_tag;
  logic [DATA_W-1:0] cmp_data;
  logic              cmp_exc;
  logic              ret_valid;
  logic [AREG_W-1:0] ret_dst;
  logic [DATA_W-1:0] ret_data;
  logic              exc_out;
  logic [TAG_W-1:0]  exc_tag;
  logic [AREG_W-1:0] rd_reg;
  logic              rd_hit;
  logic              rd_ready;
  logic [TAG_W-1:0]  rd_tag;
  logic [DATA_W-1:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cq_top #(.DEPTH(DEPTH), .AREG_W(AREG_W), .DATA_W(DATA_W)) u_cq_top (
    .clk(clk), .rst_n(rst_n),
    .alloc_req(alloc_req), .alloc_dst(alloc_dst), .alloc_ok(alloc_ok),
    .alloc_tag(alloc_tag), .full(full),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_data(cmp_data), .cmp_exc(cmp_exc),
    .ret_valid(ret_valid), .ret_dst(ret_dst), .ret_data(ret_data),
    .exc_out(exc_out), .exc_tag(exc_tag),
    .rd_reg(rd_reg), .rd_hit(rd_hit), .rd_ready(rd_ready), .rd_tag(rd_tag), .rd_data(rd_data)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic go();
    @(posedge clk);
    #1;
    alloc_req = 1'b0;
    cmp_valid = 1'b0;
    cmp_exc   = 1'b0;
    #1;
  endtask

  task automatic alloc(input int dst, input int etag, input string r);
    alloc_req = 1'b1;
    alloc_dst = AREG_W'(dst);
    #1;
    chk({r, " alloc_ok"}, 32'(alloc_ok), 32'd1);
    chk({r, " alloc_tag"}, 32'(alloc_tag), 32'(etag));
    go();
  endtask

  task automatic complete(input int tag, input logic [31:0] data, input bit exc);
    cmp_valid = 1'b1;
    cmp_tag   = TAG_W'(tag);
    cmp_data  = data;
    cmp_exc   = exc;
  endtask

  task automatic expect_ret(input int dst, input logic [31:0] data, input string r);
    #1;
    chk({r, " ret_valid"}, 32'(ret_valid), 32'd1);
    chk({r, " ret_dst"}, 32'(ret_dst), 32'(dst));
    chk({r, " ret_data"}, ret_data, data);
  endtask

  task automatic lookup(input int rg, input bit ehit, input bit erdy,
                        input logic [31:0] edata, input int etag, input string r);
    rd_reg = AREG_W'(rg);
    #1;
    chk({r, " rd_hit"}, 32'(rd_hit), 32'(ehit));
    chk({r, " rd_ready"}, 32'(rd_ready), 32'(erdy));
    if (ehit) chk({r, " rd_tag"}, 32'(rd_tag), 32'(etag));
    if (erdy) chk({r, " rd_data"}, rd_data, edata);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 full", 32'(full), 32'd0);
    chk("R1 alloc_tag", 32'(alloc_tag), 32'd0);
    chk("R1 ret_valid", 32'(ret_valid), 32'd0);
    chk("R1 exc_out", 32'(exc_out), 32'd0);
    lookup(3, 1'b0, 1'b1, 32'h0, 0, "R1 lookup");
  endtask

  task automatic t_out_of_order();
    alloc(1, 0, "R2");
    alloc(2, 1, "R2");
    alloc(3, 2, "R2");
    alloc(4, 3, "R2");
    complete(2, 32'h33, 1'b0);
    go();
    chk("R5 younger done waits", 32'(ret_valid), 32'd0);
    complete(0, 32'h11, 1'b0);
    go();
    expect_ret(1, 32'h11, "R4 first");
    complete(3, 32'h44, 1'b0);
    go();
    chk("R5 head pending", 32'(ret_valid), 32'd0);
    complete(1, 32'h22, 1'b0);
    go();
    expect_ret(2, 32'h22, "R4 second");
    go();
    expect_ret(3, 32'h33, "R4 third");
    go();
    expect_ret(4, 32'h44, "R4 fourth");
    go();
    chk("R4 drained", 32'(ret_valid), 32'd0);
    lookup(3, 1'b0, 1'b1, 32'h33, 0, "R6 committed");
  endtask

  task automatic t_forward();
    alloc(5, 4, "R7");
    alloc(5, 5, "R7");
    alloc(6, 6, "R7");
    lookup(5, 1'b1, 1'b0, 32'h0, 5, "R7 youngest pending");
    complete(5, 32'h55, 1'b0);
    go();
    lookup(5, 1'b1, 1'b1, 32'h55, 5, "R7 youngest done");
    complete(4, 32'h54, 1'b0);
    go();
    expect_ret(5, 32'h54, "R7 older retires");
    lookup(5, 1'b1, 1'b1, 32'h55, 5, "R7 still forwarded");
    go();
    expect_ret(5, 32'h55, "R7 younger retires");
    go();
    lookup(5, 1'b0, 1'b1, 32'h55, 0, "R6 fallback");
    complete(6, 32'h66, 1'b0);
    go();
    expect_ret(6, 32'h66, "R4");
    go();
  endtask

  task automatic t_full();
    for (int k = 0; k < DEPTH; k++) begin
      alloc(8 + k, (7 + k) % DEPTH, "R2 wrap");
    end
    chk("R3 full set", 32'(full), 32'd1);
    alloc_req = 1'b1;
    alloc_dst = 5'd31;
    #1;
    chk("R3 refused", 32'(alloc_ok), 32'd0);
    go();
    chk("R3 still full", 32'(full), 32'd1);
    complete(7, 32'h70, 1'b0);
    go();
    expect_ret(8, 32'h70, "R3 retire while full");
    chk("R3 full until edge", 32'(full), 32'd1);
    go();
    chk("R3 space", 32'(full), 32'd0);
    chk("R3 refused took nothing", 32'(alloc_tag), 32'd7);
    lookup(8, 1'b0, 1'b1, 32'h70, 0, "R6");
  endtask

  task automatic t_fault();
    complete(1, 32'hE1, 1'b1);
    go();
    chk("R9 fault behind older", 32'(exc_out), 32'd0);
    complete(2, 32'hA2, 1'b0);
    go();
    complete(0, 32'hA0, 1'b0);
    go();
    expect_ret(9, 32'hA0, "R9 older retires first");
    chk("R9 no exc yet", 32'(exc_out), 32'd0);
    go();
    chk("R8 exc_out", 32'(exc_out), 32'd1);
    chk("R8 exc_tag", 32'(exc_tag), 32'd1);
    chk("R8 no retire", 32'(ret_valid), 32'd0);
    alloc_req = 1'b1;
    alloc_dst = 5'd1;
    #1;
    chk("R8 alloc refused", 32'(alloc_ok), 32'd0);
    go();
    chk("R8 tag reset", 32'(alloc_tag), 32'd0);
    chk("R8 not full", 32'(full), 32'd0);
    chk("R8 exc clear", 32'(exc_out), 32'd0);
    chk("R8 idle", 32'(ret_valid), 32'd0);
    lookup(11, 1'b0, 1'b1, 32'h0, 0, "R8 done younger dropped");
    lookup(10, 1'b0, 1'b1, 32'h0, 0, "R8 faulting dropped");
    lookup(12, 1'b0, 1'b1, 32'h0, 0, "R8 pending dropped");
    lookup(9, 1'b0, 1'b1, 32'hA0, 0, "R8 older kept");
  endtask

  task automatic t_stale();
    complete(0, 32'hBAD, 1'b0);
    go();
    alloc(20, 0, "R10");
    chk("R10 no early retire", 32'(ret_valid), 32'd0);
    lookup(20, 1'b1, 1'b0, 32'h0, 0, "R10 not done");
    complete(0, 32'h20, 1'b0);
    go();
    expect_ret(20, 32'h20, "R10 real result");
    go();
    chk("R10 empty", 32'(ret_valid), 32'd0);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    alloc_req = 1'b0;
    alloc_dst = '0;
    cmp_valid = 1'b0;
    cmp_tag = '0;
    cmp_data = '0;
    cmp_exc = 1'b0;
    rd_reg = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_out_of_order();
    t_forward();
    t_full();
    t_fault();
    t_stale();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule